// File: doc/BRIEF.md
# Performance monitor counter unit

This block keeps four 32-bit event counters and a 32-bit monitor control word. Each counter picks one event strobe with its own select field and adds one on every cycle that strobe is high. Counter 1 chooses among 128 strobes. Counters 2, 3 and 4 choose among the lower 64 strobes. The block raises a level interrupt in two cases: a counter's most significant bit becomes set, or a chosen bit of a 64-bit time-base value rises from 0 to 1.

The control word and the counters are loaded through one write port. A read-only copy of the control word is driven on a separate output for user-level software. The control word also sets two optional behaviours. Freeze-on-interrupt stops the counters once the interrupt is up. Triggered start keeps counters 2 to 4 at rest until counter 1 reaches its top bit or the interrupt is raised.

Bits in this brief are numbered big-endian: control bit b is vector index 31-b, counter bit 0 is index 31, and time-base bit n is index 63-n.

Two small state machines run inside the block:
- The edge tracker has the states TB_SYNC (reset) and TB_TRACK. TB_SYNC always goes to TB_TRACK.
- The start gate has the states TRG_FREE, TRG_HOLD and TRG_RUN. A control write moves it to TRG_HOLD when the new trigger bit is 1 and to TRG_FREE when it is 0. TRG_HOLD goes to TRG_RUN when counter 1's top bit is set or the interrupt is high. TRG_RUN and TRG_FREE stay where they are until the next control write.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, all four counters, the control word and the interrupt are 0.
- R2: A write with `wr_en` high loads `wr_data` at the next clock edge. `wr_addr` 0 selects the control word and 1 to 4 select counters 1 to 4. If a counter is written in the same cycle it would count, the written value wins.
- R3: A counter adds 1 on each cycle its selected strobe is high and it is not held. Counter 1 selects from `ev_i[127:0]` using control index 12:6. Counter 2 selects from `ev_i[63:0]` using index 5:0. Counters 3 and 4 select from `ev_i[63:0]` using `sel3_i` and `sel4_i`. Counters wrap modulo 2^32.
- R4: `user_ctrl_o` always equals `ctrl_o`.
- R5: The time-base selector sits at control index 24:23. Code 00 watches `tb_i[0]`, 01 watches `tb_i[8]`, 10 watches `tb_i[12]` and 11 watches `tb_i[16]`. A rise on any other bit has no effect on the interrupt.
- R6: A rise of the watched bit from one cycle to the next raises the interrupt when the edge enable (index 22) and the global enable (index 26) are both 1. No edge is reported in the first cycle after reset, or in the cycle in which the selector code changes.
- R7: While the global enable, counter 1's enable (index 15) and counter 1's index 31 are all 1, the interrupt is raised.
- R8: While the global enable, the shared enable for counters 2 to 4 (index 14) and index 31 of any of counters 2 to 4 are all 1, the interrupt is raised. Counter 1's enable alone does not raise it for them.
- R9: `pmi_o` goes high at the edge after a raising condition. It stays high while the global enable is 1 and goes low at the edge after the global enable reads 0.
- R10: When the freeze bit (index 25) is 1 and `pmi_o` is high, counter 1 holds. Counters 2 to 4 also hold, unless the shared enable (index 14) is 1, in which case they keep counting.
- R11: When a control write sets the trigger bit (index 13), counters 2 to 4 hold until counter 1's index 31 or `pmi_o` has been seen high. After that they count until the next control write. With the trigger bit written as 0, they count freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write target: 0 control, 1 to 4 counters |
| wr_data | input | 32 | Write value |
| ev_i | input | 128 | Event increment strobes |
| sel3_i | input | 6 | Event select for counter 3 |
| sel4_i | input | 6 | Event select for counter 4 |
| tb_i | input | 64 | Time-base value |
| pmi_o | output | 1 | Performance-monitor interrupt level |
| ctrl_o | output | 32 | Control word |
| user_ctrl_o | output | 32 | Read-only user copy of the control word |
| cnt1_o | output | 32 | Counter 1 |
| cnt2_o | output | 32 | Counter 2 |
| cnt3_o | output | 32 | Counter 3 |
| cnt4_o | output | 32 | Counter 4 |

## Verification
A register write and an event increment can land on the same counter in the same cycle. The bench provokes this directly, by loading counter 1 while its strobe is held high, and through dense random strobes that overlap random writes. It judges the result against a cycle-level reference model in which the written value always wins. A time-base edge can also arrive in the same cycle as a counter reaching its top bit. The random phase, which combines fast time-base steps with near-overflow preloads, checks that both sources merge into one interrupt level with the same timing.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    // Control word field positions as vector indices (big-endian bit b = index 31-b)
    localparam int CTRL_W   = 32;
    localparam int F_GIE    = 26;
    localparam int F_FRZ    = 25;
    localparam int F_TBS_HI = 24;
    localparam int F_TBS_LO = 23;
    localparam int F_TEN    = 22;
    localparam int F_IE1    = 15;
    localparam int F_IE234  = 14;
    localparam int F_TRG    = 13;
    localparam int F_S1_HI  = 12;
    localparam int F_S1_LO  = 6;
    localparam int F_S2_HI  = 5;
    localparam int F_S2_LO  = 0;

    typedef enum logic [1:0] {
        TRG_FREE = 2'd0,
        TRG_HOLD = 2'd1,
        TRG_RUN  = 2'd2
    } trg_state_e;

    typedef enum logic {
        TB_SYNC  = 1'b0,
        TB_TRACK = 1'b1
    } tb_state_e;
endpackage

// File: rtl/perfmon_tb_edge.sv
module perfmon_tb_edge
    import perfmon_pkg::*;
#(
    parameter int TB_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TB_W-1:0] tb_i,
    input  logic [1:0]      code_i,
    output logic            rise_o
);
    // big-endian time-base bit n lives at index TB_W-1-n
    localparam int IDX_A = TB_W - 1 - 63;
    localparam int IDX_B = TB_W - 1 - 55;
    localparam int IDX_C = TB_W - 1 - 51;
    localparam int IDX_D = TB_W - 1 - 47;

    tb_state_e  state_q;
    logic       prev_q;
    logic [1:0] code_q;
    logic       cur_bit;
    logic       unused_tb;

    assign unused_tb = ^tb_i;

    always_comb begin
        unique case (code_i)
            2'b00:   cur_bit = tb_i[IDX_A];
            2'b01:   cur_bit = tb_i[IDX_B];
            2'b10:   cur_bit = tb_i[IDX_C];
            default: cur_bit = tb_i[IDX_D];
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TB_SYNC;
            prev_q  <= 1'b0;
            code_q  <= 2'b00;
        end else begin
            unique case (state_q)
                TB_SYNC:  state_q <= TB_TRACK;
                TB_TRACK: state_q <= TB_TRACK;
                default:  state_q <= TB_SYNC;
            endcase
            prev_q <= cur_bit;
            code_q <= code_i;
        end
    end

    // outputs
    always_comb begin
        rise_o = 1'b0;
        unique case (state_q)
            TB_SYNC:  rise_o = 1'b0;
            TB_TRACK: rise_o = (code_i == code_q) && cur_bit && !prev_q;
            default:  rise_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/perfmon_trigger.sv
module perfmon_trigger
    import perfmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic trg_bit_i,
    input  logic c1_msb_i,
    input  logic pmi_i,
    output logic go_o,
    output logic hold_o
);
    trg_state_e state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRG_FREE;
        end else if (ctrl_wr_i) begin
            state_q <= trg_bit_i ? TRG_HOLD : TRG_FREE;
        end else begin
            unique case (state_q)
                TRG_FREE: state_q <= TRG_FREE;
                TRG_HOLD: state_q <= (c1_msb_i || pmi_i) ? TRG_RUN : TRG_HOLD;
                TRG_RUN:  state_q <= TRG_RUN;
                default:  state_q <= TRG_FREE;
            endcase
        end
    end

    // outputs
    always_comb begin
        go_o   = 1'b1;
        hold_o = 1'b0;
        unique case (state_q)
            TRG_FREE: go_o = 1'b1;
            TRG_HOLD: begin
                go_o   = 1'b0;
                hold_o = 1'b1;
            end
            TRG_RUN:  go_o = 1'b1;
            default:  go_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int CNT_W = 32,
    parameter int EV_W  = 64,
    localparam int SEL_W = $clog2(EV_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [EV_W-1:0]  ev_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = ev_i[sel_i] && run_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (wr_i) cnt_q <= wr_data_i;
        else if (hit)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EV1_N = 128,
    parameter int EVX_N = 64,
    parameter int TB_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [127:0]     ev_i,
    input  logic [5:0]       sel3_i,
    input  logic [5:0]       sel4_i,
    input  logic [63:0]      tb_i,
    output logic             pmi_o,
    output logic [31:0]      ctrl_o,
    output logic [31:0]      user_ctrl_o,
    output logic [CNT_W-1:0] cnt1_o,
    output logic [CNT_W-1:0] cnt2_o,
    output logic [CNT_W-1:0] cnt3_o,
    output logic [CNT_W-1:0] cnt4_o
);
    localparam int NUM_CNT = 4;
    localparam int SEL1_W  = $clog2(EV1_N);
    localparam int SELX_W  = $clog2(EVX_N);

    logic [CTRL_W-1:0] ctrl_q;
    logic              pmi_q;
    logic [CNT_W-1:0]  cnt_q [NUM_CNT];
    logic [SELX_W-1:0] selx  [NUM_CNT];
    logic [NUM_CNT-1:0] run;
    logic [NUM_CNT-1:0] cnt_wr;
    logic              tb_rise;
    logic              trg_go;
    logic              trg_hold;
    logic              gie;
    logic              frozen;
    logic              msb_other;
    logic              int_ev;
    logic              ctrl_wr;

    assign gie     = ctrl_q[F_GIE];
    assign ctrl_wr = wr_en && (wr_addr == 3'd0);

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wr_data;
    end

    // time-base edge tracker
    perfmon_tb_edge #(.TB_W(TB_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tb_i   (tb_i),
        .code_i (ctrl_q[F_TBS_HI:F_TBS_LO]),
        .rise_o (tb_rise)
    );

    // triggered start gate
    perfmon_trigger u_trg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (ctrl_wr),
        .trg_bit_i (wr_data[F_TRG]),
        .c1_msb_i  (cnt_q[0][CNT_W-1]),
        .pmi_i     (pmi_q),
        .go_o      (trg_go),
        .hold_o    (trg_hold)
    );

    // interrupt sources
    assign msb_other = cnt_q[1][CNT_W-1] | cnt_q[2][CNT_W-1] | cnt_q[3][CNT_W-1];
    assign int_ev = gie && ((ctrl_q[F_IE1]   && cnt_q[0][CNT_W-1]) ||
                            (ctrl_q[F_IE234] && msb_other) ||
                            (ctrl_q[F_TEN]   && tb_rise));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pmi_q <= 1'b0;
        else if (!gie) pmi_q <= 1'b0;
        else if (int_ev) pmi_q <= 1'b1;
    end

    assign frozen = ctrl_q[F_FRZ] && pmi_q;

    // event selects for counters 2..4
    assign selx[0] = '0;
    assign selx[1] = ctrl_q[F_S2_HI:F_S2_LO];
    assign selx[2] = sel3_i;
    assign selx[3] = sel4_i;

    genvar g;
    generate
        for (g = 0; g < NUM_CNT; g++) begin : g_cnt
            assign cnt_wr[g] = wr_en && (wr_addr == 3'(g + 1));
            if (g == 0) begin : g_first
                assign run[g] = !frozen;
                perfmon_counter #(.CNT_W(CNT_W), .EV_W(EV1_N)) u_cnt (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .wr_i      (cnt_wr[g]),
                    .wr_data_i (wr_data[CNT_W-1:0]),
                    .ev_i      (ev_i[EV1_N-1:0]),
                    .sel_i     (ctrl_q[F_S1_HI:F_S1_LO]),
                    .run_i     (run[g]),
                    .cnt_o     (cnt_q[g])
                );
            end else begin : g_rest
                assign run[g] = trg_go && !(frozen && !ctrl_q[F_IE234]);
                perfmon_counter #(.CNT_W(CNT_W), .EV_W(EVX_N)) u_cnt (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .wr_i      (cnt_wr[g]),
                    .wr_data_i (wr_data[CNT_W-1:0]),
                    .ev_i      (ev_i[EVX_N-1:0]),
                    .sel_i     (selx[g]),
                    .run_i     (run[g]),
                    .cnt_o     (cnt_q[g])
                );
            end
        end
    endgenerate

    logic unused_sel;
    assign unused_sel = ^selx[0] ^ trg_hold;

    assign pmi_o       = pmi_q;
    assign ctrl_o      = ctrl_q;
    assign user_ctrl_o = ctrl_q;
    assign cnt1_o      = cnt_q[0];
    assign cnt2_o      = cnt_q[1];
    assign cnt3_o      = cnt_q[2];
    assign cnt4_o      = cnt_q[3];
endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [31:0] ctrl,
    input logic [31:0] user_ctrl,
    input logic        pmi,
    input logic [31:0] cnt1,
    input logic [31:0] cnt2,
    input logic        trg_hold
);
    assert_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        user_ctrl == ctrl);

    assert_pmi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi && ctrl[26]) |=> pmi);

    assert_pmi_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[26] |=> !pmi);

    assert_c1_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[26] && ctrl[15] && cnt1[31]) |=> pmi);

    assert_freeze_c1_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[25] && pmi && !(wr_en && wr_addr == 3'd1)) |=> $stable(cnt1));

    assert_trig_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_hold && !(wr_en && wr_addr == 3'd2)) |=> $stable(cnt2));
endmodule

bind perfmon_unit perfmon_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ctrl      (ctrl_o),
    .user_ctrl (user_ctrl_o),
    .pmi       (pmi_o),
    .cnt1      (cnt1_o),
    .cnt2      (cnt2_o),
    .trg_hold  (trg_hold)
);

// File: tb/perfmon_unit_bench.sv
module perfmon_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [127:0] ev_i = '0;
    logic [5:0]   sel3_i = '0;
    logic [5:0]   sel4_i = '0;
    logic [63:0]  tb_i = '0;
    logic         pmi_o;
    logic [31:0]  ctrl_o, user_ctrl_o, cnt1_o, cnt2_o, cnt3_o, cnt4_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    perfmon_unit u_perfmon_unit (.*);

    // control word bit constants (vector index = 31 - big-endian bit)
    localparam logic [31:0] GIE   = 32'h1 << 26;
    localparam logic [31:0] FRZ   = 32'h1 << 25;
    localparam logic [31:0] TEN   = 32'h1 << 22;
    localparam logic [31:0] IE1   = 32'h1 << 15;
    localparam logic [31:0] IE234 = 32'h1 << 14;
    localparam logic [31:0] TRG   = 32'h1 << 13;

    function automatic logic [31:0] tbsel(input logic [1:0] c);
        return {30'd0, c} << 23;
    endfunction

    function automatic int watch_idx(input logic [1:0] c);
        case (c)
            2'd0: return 0;
            2'd1: return 8;
            2'd2: return 12;
            default: return 16;
        endcase
    endfunction

    // reference model
    logic [31:0] m_ctrl;
    logic [31:0] m_cnt [4];
    logic        m_pmi, m_prev, m_sync;
    logic [1:0]  m_code;
    int          m_trg;   // 0 free, 1 hold, 2 run

    initial begin
        m_ctrl = 0; m_pmi = 0; m_prev = 0; m_sync = 1; m_code = 0; m_trg = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_pmi = 0; m_prev = 0; m_sync = 1; m_code = 0; m_trg = 0;
            for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        end else begin
            logic [1:0] code;
            logic cur, rise, gie, iev, frz, anyx;
            logic [31:0] n_cnt [4];
            int sel;
            int n_trg;
            code = m_ctrl[24:23];
            cur  = tb_i[watch_idx(code)];
            rise = !m_sync && (code == m_code) && cur && !m_prev;
            gie  = m_ctrl[26];
            anyx = m_cnt[1][31] | m_cnt[2][31] | m_cnt[3][31];
            iev  = gie && ((m_ctrl[15] && m_cnt[0][31]) || (m_ctrl[14] && anyx) ||
                           (m_ctrl[22] && rise));
            frz  = m_ctrl[25] && m_pmi;
            for (int i = 0; i < 4; i++) begin
                logic run;
                case (i)
                    0: sel = int'(m_ctrl[12:6]);
                    1: sel = int'(m_ctrl[5:0]);
                    2: sel = int'(sel3_i);
                    default: sel = int'(sel4_i);
                endcase
                if (i == 0) run = !frz;
                else run = (m_trg != 1) && !(frz && !m_ctrl[14]);
                n_cnt[i] = m_cnt[i];
                if (wr_en && wr_addr == 3'(i + 1)) n_cnt[i] = wr_data;
                else if (run && ev_i[sel]) n_cnt[i] = m_cnt[i] + 1;
            end
            n_trg = m_trg;
            if (wr_en && wr_addr == 0) n_trg = wr_data[13] ? 1 : 0;
            else if (m_trg == 1 && (m_cnt[0][31] || m_pmi)) n_trg = 2;
            m_pmi  = gie ? (m_pmi | iev) : 1'b0;
            m_prev = cur;
            m_code = code;
            m_sync = 0;
            m_trg  = n_trg;
            for (int i = 0; i < 4; i++) m_cnt[i] = n_cnt[i];
            if (wr_en && wr_addr == 0) m_ctrl = wr_data;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        check("R3 cnt1", cnt1_o, m_cnt[0]);
        check("R3 cnt2", cnt2_o, m_cnt[1]);
        check("R3 cnt3", cnt3_o, m_cnt[2]);
        check("R3 cnt4", cnt4_o, m_cnt[3]);
        check("R2 ctrl", ctrl_o, m_ctrl);
        check("R4 user", user_ctrl_o, m_ctrl);
        check("R9 pmi", {31'd0, pmi_o}, {31'd0, m_pmi});
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        logic [31:0] c1, c2;
        void'($urandom(32'd1357));
        step(3);
        // R1 reset state
        check("R1 cnt1", cnt1_o, 0);
        check("R1 cnt4", cnt4_o, 0);
        check("R1 ctrl", ctrl_o, 0);
        check("R1 pmi", {31'd0, pmi_o}, 0);
        rst_n = 1;
        step(1);

        // R3 counting, R2 write priority
        wr(0, GIE | (32'd100 << 6));
        check("R4 user mirror", user_ctrl_o, GIE | (32'd100 << 6));
        wr(1, 32'd5);
        ev_i[100] = 1;
        step(3);
        check("R3 cnt1 after 3 events", cnt1_o, 32'd8);
        wr_en = 1; wr_addr = 1; wr_data = 32'd20;
        step(1);
        wr_en = 0; ev_i = '0;
        check("R2 write beats increment", cnt1_o, 32'd20);
        sel3_i = 6'd7; ev_i[7] = 1;
        step(2);
        ev_i = '0;
        check("R3 cnt3 via port select", cnt3_o, 32'd2);
        cmp_model();

        // R5/R6 time-base selection
        tb_i = '0;
        wr(0, GIE | TEN | tbsel(2'b01));
        step(2);
        tb_i = 64'h1 << 12;
        step(2);
        check("R5 unwatched bit ignored", {31'd0, pmi_o}, 0);
        tb_i = tb_i | (64'h1 << 8);
        step(1);
        check("R6 watched bit rise", {31'd0, pmi_o}, 1);
        step(3);
        check("R9 interrupt stays", {31'd0, pmi_o}, 1);
        wr(0, 32'd0);
        step(1);
        check("R9 cleared by global enable", {31'd0, pmi_o}, 0);

        // R6 selector change gives no false edge
        tb_i = 64'h1 << 16;
        wr(0, GIE | TEN | tbsel(2'b00));
        step(2);
        wr(0, GIE | TEN | tbsel(2'b11));
        step(3);
        check("R6 no edge on selector change", {31'd0, pmi_o}, 0);
        tb_i = '0;
        step(1);
        tb_i = 64'h1 << 16;
        step(2);
        check("R5 code 11 watches index 16", {31'd0, pmi_o}, 1);
        wr(0, 32'd0);
        cmp_model();

        // R7/R8 overflow sources
        wr(1, 32'h8000_0000);
        wr(0, GIE | IE1);
        step(1);
        check("R7 counter1 overflow", {31'd0, pmi_o}, 1);
        wr(0, 32'd0);
        wr(1, 32'd0);
        wr(3, 32'h8000_0000);
        wr(0, GIE | IE1);
        step(2);
        check("R8 counter3 needs shared enable", {31'd0, pmi_o}, 0);
        wr(0, GIE | IE234);
        step(1);
        check("R8 counter3 overflow", {31'd0, pmi_o}, 1);
        wr(0, 32'd0);
        wr(3, 32'd0);
        cmp_model();

        // R10 freeze
        sel3_i = 0; sel4_i = 0;
        ev_i = '1;
        wr(1, 32'h7FFF_FFFC);
        wr(0, GIE | IE1 | FRZ);
        step(10);
        c1 = cnt1_o; c2 = cnt2_o;
        step(3);
        check("R10 pmi up", {31'd0, pmi_o}, 1);
        check("R10 cnt1 frozen", cnt1_o, c1);
        check("R10 cnt2 frozen", cnt2_o, c2);
        wr(0, GIE | IE1 | FRZ | IE234);
        c1 = cnt1_o; c2 = cnt2_o;
        step(3);
        check("R10 cnt1 still frozen", cnt1_o, c1);
        check("R10 cnt2 runs with shared enable", cnt2_o, c2 + 3);
        wr(0, 32'd0);
        cmp_model();

        // R11 trigger
        wr(2, 32'd0);
        wr(1, 32'd0);
        wr(0, TRG);
        c2 = cnt2_o;
        step(4);
        check("R11 cnt2 held", cnt2_o, c2);
        wr(1, 32'h8000_0000);
        c2 = cnt2_o;
        step(3);
        check("R11 cnt2 starts after cnt1 top bit", cnt2_o, c2 + 2);
        wr(0, 32'd0);
        ev_i = '0;
        cmp_model();

        // random phase
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            cmp_model();
            ev_i   = {$urandom, $urandom, $urandom, $urandom} &
                     {$urandom, $urandom, $urandom, $urandom};
            sel3_i = 6'($urandom);
            sel4_i = 6'($urandom);
            tb_i   = tb_i + 64'($urandom_range(0, 6000));
            wr_en  = ($urandom_range(0, 11) == 0);
            wr_addr = 3'($urandom_range(0, 4));
            if (wr_addr == 0)
                wr_data = $urandom | (($urandom_range(0, 3) != 0) ? GIE : 32'd0);
            else
                wr_data = $urandom_range(0, 1) ? (32'h7FFF_FF00 + 32'($urandom_range(0, 255)))
                                               : $urandom;
        end
        @(negedge clk);
        wr_en = 0;
        cmp_model();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule